// File: doc/BRIEF.md
# String Repeat Iteration Sequencer

This block runs the repeat loop of one string instruction. When an instruction is dispatched to it, the block decides from the prefix, the repeatable marks and the selected part of the count register whether the string operation runs at all. It then issues one execute strobe per iteration, waits for that iteration's acknowledge and zero flag, and decrements the count. After each iteration it decides whether the loop is over.

A loop can end on a count of zero or, for compare-type instructions, on the zero flag. When it ends, the block retires the instruction and the pointer moves past it by the instruction length. If an asynchronous event is waiting after an iteration that did not end the loop, the block asks for a restart instead. In that case the pointer stays on the instruction and the partly decremented count is kept, so the loop resumes later where it stopped. An instruction with no repeat prefix, or one that is not repeatable, executes exactly once.

Top module: `strrep_sequencer`

## Requirements
- R1: `addr_size` selects the active count bits (0: low 16 bits, 1: low 32 bits, 2: all 64 bits). Only those bits are tested and decremented. Bits above them keep their value in `count_out`.
- R2: A repeated instruction whose active count is zero at dispatch issues no `exec_go`. It retires with one `tick` and leaves the count unchanged.
- R3: Each acknowledged iteration of a repeated instruction lowers the active count by exactly one. The count changes at no other time while `busy` is high.
- R4: With `zf_sens`=1 and `pfx_code`=3, the loop ends after an iteration that returns `iter_zf`=0.
- R5: With `zf_sens`=1 and `pfx_code`=2, the loop ends after an iteration that returns `iter_zf`=1.
- R6: Whatever the prefix code and the flag, the loop ends after the iteration that brings the active count to zero.
- R7: With `zf_sens`=0 the value of `iter_zf` has no effect on the number of iterations.
- R8: On retire, `retire` is high for one cycle and `ip_out` equals `ip_in` plus `instr_len`.
- R9: If `event_pend` is high with the acknowledge of an iteration that did not end the loop, `restart` pulses instead of `retire`. `ip_out` then equals `ip_in` and `count_out` holds the count left over. An event that arrives with the final iteration is ignored.
- R10: With `rep_en`=0 or `str_op`=0, the instruction executes exactly once. It then retires and leaves the count unchanged.
- R11: `tick` pulses once per acknowledged iteration. A zero-count entry produces a single `tick`.
- R12: `exec_go` is a one-cycle pulse and is low after reset. Between two pulses there is always an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Dispatch of one instruction (accepted when not busy) |
| rep_en | input | 1 | Instruction carries a repeat prefix |
| str_op | input | 1 | Instruction is a repeatable string operation |
| zf_sens | input | 1 | Instruction ends on the zero flag when repeated |
| pfx_code | input | 2 | Prefix code: 3 repeat while equal, 2 repeat while not equal |
| addr_size | input | 2 | 0: 16-bit, 1: 32-bit, 2: 64-bit count |
| count_in | input | 64 | Count register at dispatch |
| ip_in | input | 64 | Pointer of the instruction |
| instr_len | input | 4 | Instruction length in bytes |
| iter_ack | input | 1 | Current iteration finished |
| iter_zf | input | 1 | Zero flag from the finished iteration |
| event_pend | input | 1 | Asynchronous event waiting |
| exec_go | output | 1 | Start one iteration |
| tick | output | 1 | One time tick |
| retire | output | 1 | Instruction complete, pointer advanced and committed |
| restart | output | 1 | Yield: fetch window invalid, instruction restarts later |
| busy | output | 1 | Instruction in progress |
| count_out | output | 64 | Current count register value |
| ip_out | output | 64 | Pointer to commit |

## Verification
The hardest case to reach is an event that arrives between iterations. It has to coincide with the acknowledge of an iteration that neither empties the count nor meets the zero-flag stop condition. The bench responder raises `event_pend` with a chosen acknowledge to produce a restart with a partial count. It also raises the event on the final acknowledge, where the event must be ignored. The flag-ignoring case is driven by giving a plain repeat the very flag values that would stop a compare loop.

// File: rtl/strrep_pkg.sv
package strrep_pkg;
    localparam int ASZ_W = 2;
    localparam int PFX_W = 2;
    localparam logic [PFX_W-1:0] PFX_WHILE_NE = 2'd2;
    localparam logic [PFX_W-1:0] PFX_WHILE_EQ = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RETIRE,
        ST_RESTART
    } seq_state_e;
endpackage

// File: rtl/strrep_count_lane.sv
module strrep_count_lane
    import strrep_pkg::*;
#(
    parameter int CNT_W     = 64,
    parameter int NUM_SIZES = 3,
    parameter int BASE_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [ASZ_W-1:0] size_sel,
    output logic             cur_zero,
    output logic             next_zero,
    output logic [CNT_W-1:0] cnt_dec
);
    localparam logic [ASZ_W-1:0] LAST_SEL = ASZ_W'(NUM_SIZES - 1);

    function automatic logic [CNT_W-1:0] lane_mask(input int width);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) begin
            m[i] = (i < width);
        end
        return m;
    endfunction

    logic [CNT_W-1:0] masks [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = BASE_W << g;
        assign masks[g] = lane_mask(LW);
    end

    logic [ASZ_W-1:0] sel_idx;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] dec_bits;

    always_comb begin
        sel_idx   = (size_sel > LAST_SEL) ? LAST_SEL : size_sel;
        mask      = masks[sel_idx];
        cur_zero  = ((cnt & mask) == '0);
        dec_bits  = (cnt - CNT_W'(1)) & mask;
        next_zero = (dec_bits == '0);
        cnt_dec   = (cnt & ~mask) | dec_bits;
    end

    // R3
    lane_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_zero |-> (cnt_dec != cnt));
endmodule

// File: rtl/strrep_stop_eval.sv
module strrep_stop_eval
    import strrep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zf_sens,
    input  logic [PFX_W-1:0] pfx,
    input  logic             zf,
    input  logic             cnt_empty,
    output logic             stop
);
    logic flag_stop;

    always_comb begin
        flag_stop = 1'b0;
        if (zf_sens) begin
            if (pfx == PFX_WHILE_EQ && !zf) flag_stop = 1'b1;
            if (pfx == PFX_WHILE_NE &&  zf) flag_stop = 1'b1;
        end
        stop = flag_stop | cnt_empty;
    end

    // R6
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_empty |-> stop);

    // R7
    insens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!zf_sens && !cnt_empty) |-> !stop);
endmodule

// File: rtl/strrep_sequencer.sv
module strrep_sequencer
    import strrep_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int IP_W  = 64,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rep_en,
    input  logic             str_op,
    input  logic             zf_sens,
    input  logic [1:0]       pfx_code,
    input  logic [1:0]       addr_size,
    input  logic [CNT_W-1:0] count_in,
    input  logic [IP_W-1:0]  ip_in,
    input  logic [LEN_W-1:0] instr_len,
    input  logic             iter_ack,
    input  logic             iter_zf,
    input  logic             event_pend,
    output logic             exec_go,
    output logic             tick,
    output logic             retire,
    output logic             restart,
    output logic             busy,
    output logic [CNT_W-1:0] count_out,
    output logic [IP_W-1:0]  ip_out
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IP_W-1:0]  ip;
        logic [IP_W-1:0]  base;
        logic [LEN_W-1:0] len;
        logic [ASZ_W-1:0] asz;
        logic             rep;
        logic             zfs;
        logic [PFX_W-1:0] pfx;
        logic             tick;
    } seq_ctx_t;

    seq_ctx_t ctx_d, ctx_q;

    logic             idle_q;
    logic [CNT_W-1:0] lane_cnt;
    logic [ASZ_W-1:0] lane_asz;
    logic             lane_cur_zero;
    logic             lane_next_zero;
    logic [CNT_W-1:0] lane_dec;
    logic             stop_now;

    assign idle_q   = (ctx_q.st == ST_IDLE);
    assign lane_cnt = idle_q ? count_in  : ctx_q.cnt;
    assign lane_asz = idle_q ? addr_size : ctx_q.asz;

    strrep_count_lane #(
        .CNT_W    (CNT_W),
        .NUM_SIZES(3),
        .BASE_W   (16)
    ) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (lane_cnt),
        .size_sel (lane_asz),
        .cur_zero (lane_cur_zero),
        .next_zero(lane_next_zero),
        .cnt_dec  (lane_dec)
    );

    strrep_stop_eval u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .zf_sens  (ctx_q.zfs),
        .pfx      (ctx_q.pfx),
        .zf       (iter_zf),
        .cnt_empty(lane_next_zero),
        .stop     (stop_now)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.tick = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.cnt  = count_in;
                    ctx_d.ip   = ip_in;
                    ctx_d.base = ip_in;
                    ctx_d.len  = instr_len;
                    ctx_d.asz  = addr_size;
                    ctx_d.rep  = rep_en & str_op;
                    ctx_d.zfs  = zf_sens;
                    ctx_d.pfx  = pfx_code;
                    if (rep_en && str_op && lane_cur_zero) begin
                        ctx_d.st   = ST_RETIRE;
                        ctx_d.tick = 1'b1;
                        ctx_d.ip   = ip_in + IP_W'(instr_len);
                    end else begin
                        ctx_d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: ctx_d.st = ST_WAIT;
            ST_WAIT: begin
                if (iter_ack) begin
                    ctx_d.tick = 1'b1;
                    if (!ctx_q.rep) begin
                        ctx_d.st = ST_RETIRE;
                        ctx_d.ip = ctx_q.base + IP_W'(ctx_q.len);
                    end else begin
                        ctx_d.cnt = lane_dec;
                        if (stop_now) begin
                            ctx_d.st = ST_RETIRE;
                            ctx_d.ip = ctx_q.base + IP_W'(ctx_q.len);
                        end else if (event_pend) begin
                            ctx_d.st = ST_RESTART;
                        end else begin
                            ctx_d.st = ST_ISSUE;
                        end
                    end
                end
            end
            ST_RETIRE:  ctx_d.st = ST_IDLE;
            ST_RESTART: ctx_d.st = ST_IDLE;
            default:    ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign exec_go   = (ctx_q.st == ST_ISSUE);
    assign retire    = (ctx_q.st == ST_RETIRE);
    assign restart   = (ctx_q.st == ST_RESTART);
    assign busy      = !idle_q;
    assign tick      = ctx_q.tick;
    assign count_out = ctx_q.cnt;
    assign ip_out    = ctx_q.ip;

    // R12
    exec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |=> !exec_go);

    // R9
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exec_go, retire, restart}));

    // R9
    restart_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> $stable(ip_out));

    // R8
    retire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire && !busy);

    // R11
    tick_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_WAIT && iter_ack) |=> tick);

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(ctx_q.st == ST_WAIT && iter_ack)) |=> $stable(count_out));
endmodule

// File: tb/strrep_sequencer_test.sv
module strrep_sequencer_test;
    localparam int NV = 13;

    typedef struct packed {
        logic        rep;
        logic        sop;
        logic        zfs;
        logic [1:0]  pfx;
        logic [1:0]  asz;
        logic [63:0] cnt;
        logic [7:0]  zf_bits;
        logic [3:0]  ev_at;
        logic [7:0]  exp_iters;
        logic [63:0] exp_cnt;
        logic        exp_restart;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R1 R7: plain repeat, 16-bit count, flag 0 ignored
        '{1'b1,1'b1,1'b0,2'd3,2'd0,64'h1234_0000_0000_0005,8'h00,4'd0,8'd5,64'h1234_0000_0000_0000,1'b0},
        // R2: 16-bit active count zero
        '{1'b1,1'b1,1'b0,2'd3,2'd0,64'h0000_0000_0001_0000,8'h00,4'd0,8'd0,64'h0000_0000_0001_0000,1'b0},
        // R2: 32-bit active count zero
        '{1'b1,1'b1,1'b1,2'd3,2'd1,64'h0000_0001_0000_0000,8'h00,4'd0,8'd0,64'h0000_0001_0000_0000,1'b0},
        // R1: 32-bit count, upper bits kept
        '{1'b1,1'b1,1'b0,2'd2,2'd1,64'hFFFF_FFFF_0000_0003,8'hFF,4'd0,8'd3,64'hFFFF_FFFF_0000_0000,1'b0},
        // R3: 64-bit count
        '{1'b1,1'b1,1'b0,2'd3,2'd2,64'd4,8'h55,4'd0,8'd4,64'd0,1'b0},
        // R4: while equal, flag 0 on fourth iteration
        '{1'b1,1'b1,1'b1,2'd3,2'd2,64'd10,8'hF7,4'd0,8'd4,64'd6,1'b0},
        // R5: while not equal, flag 1 on sixth iteration
        '{1'b1,1'b1,1'b1,2'd2,2'd0,64'd10,8'h20,4'd0,8'd6,64'd4,1'b0},
        // R6: while equal, flag stays 1, count runs out
        '{1'b1,1'b1,1'b1,2'd3,2'd1,64'd2,8'hFF,4'd0,8'd2,64'd0,1'b0},
        // R9: event after third of six iterations
        '{1'b1,1'b1,1'b0,2'd3,2'd1,64'd6,8'h00,4'd3,8'd3,64'd3,1'b1},
        // R9: event with final iteration ignored
        '{1'b1,1'b1,1'b0,2'd3,2'd1,64'd2,8'h00,4'd2,8'd2,64'd0,1'b0},
        // R10: no prefix, zero count, runs once
        '{1'b0,1'b1,1'b0,2'd3,2'd0,64'd0,8'h00,4'd0,8'd1,64'd0,1'b0},
        // R10: not repeatable, runs once, count untouched
        '{1'b1,1'b0,1'b1,2'd3,2'd2,64'd5,8'h00,4'd0,8'd1,64'd5,1'b0},
        // R4: while equal, first flag 0 ends at once
        '{1'b1,1'b1,1'b1,2'd3,2'd0,64'd7,8'h00,4'd0,8'd1,64'd6,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, rep_en = 1'b0, str_op = 1'b0, zf_sens = 1'b0;
    logic [1:0]  pfx_code = '0, addr_size = '0;
    logic [63:0] count_in = '0, ip_in = '0;
    logic [3:0]  instr_len = '0;
    logic        iter_ack = 1'b0, iter_zf = 1'b0, event_pend = 1'b0;
    logic        exec_go, tick, retire, restart, busy;
    logic [63:0] count_out, ip_out;

    int checks = 0;
    int errors = 0;
    string tags [NV];

    always #10 clk = ~clk;

    strrep_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rep_en(rep_en), .str_op(str_op),
        .zf_sens(zf_sens), .pfx_code(pfx_code), .addr_size(addr_size),
        .count_in(count_in), .ip_in(ip_in), .instr_len(instr_len),
        .iter_ack(iter_ack), .iter_zf(iter_zf), .event_pend(event_pend),
        .exec_go(exec_go), .tick(tick), .retire(retire), .restart(restart),
        .busy(busy), .count_out(count_out), .ip_out(ip_out)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input vec_t v, input logic [63:0] ip, input logic [3:0] len);
        int iters = 0;
        int ticks = 0;
        int gos_wo_ack = 0;
        logic pend = 1'b0;
        logic saw_retire = 1'b0;
        logic saw_restart = 1'b0;
        @(negedge clk);
        start = 1'b1; rep_en = v.rep; str_op = v.sop; zf_sens = v.zfs;
        pfx_code = v.pfx; addr_size = v.asz; count_in = v.cnt; ip_in = ip; instr_len = len;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            iter_ack = 1'b0; event_pend = 1'b0; iter_zf = 1'b0;
            if (tick) ticks++;
            if (retire) begin saw_retire = 1'b1; break; end
            if (restart) begin saw_restart = 1'b1; break; end
            if (pend) begin
                iter_ack = 1'b1;
                iter_zf = v.zf_bits[(iters > 7) ? 7 : iters];
                iters++;
                event_pend = (v.ev_at != 0) && (iters >= int'(v.ev_at));
                pend = 1'b0;
                gos_wo_ack = 0;
            end else if (exec_go) begin
                pend = 1'b1;
                gos_wo_ack++;
                if (gos_wo_ack > 1) check(tag, "exec_go without ack (R12)", 1, 0);
            end
            @(negedge clk);
        end
        check(tag, "iterations", 64'(iters), 64'(v.exp_iters));
        check(tag, "count_out", count_out, v.exp_cnt);
        check(tag, "restart", {63'd0, saw_restart}, {63'd0, v.exp_restart});
        check(tag, "retire", {63'd0, saw_retire}, {63'd0, !v.exp_restart});
        check(tag, "ip_out (R8)", ip_out, v.exp_restart ? ip : ip + 64'(len));
        check(tag, "ticks (R11)", 64'(ticks), (v.exp_iters == 0) ? 64'd1 : 64'(v.exp_iters));
        @(negedge clk);
        check(tag, "idle after end", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R2"; tags[3] = "R1";
        tags[4] = "R3"; tags[5] = "R4"; tags[6] = "R5"; tags[7] = "R6";
        tags[8] = "R9"; tags[9] = "R9"; tags[10] = "R10"; tags[11] = "R10";
        tags[12] = "R4";
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "exec_go at reset", {63'd0, exec_go}, 64'd0);
        check("R12", "busy at reset", {63'd0, busy}, 64'd0);
        check("R8", "retire at reset", {63'd0, retire}, 64'd0);
        check("R11", "tick at reset", {63'd0, tick}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            run_one(tags[i], VECS[i], 64'h1000 + 64'(i) * 64'h40, 4'(i % 15 + 1));
        end
        // R1: 16-bit lane, one left, upper bits set
        run_one("R1", '{1'b1,1'b1,1'b0,2'd3,2'd0,64'hABCD_0001,8'h00,4'd0,8'd1,64'hABCD_0000,1'b0},
                64'hFFFF_FFFF_FFFF_FFF8, 4'd15);
        // R7: plain repeat fed flag 1 with while-not-equal code
        run_one("R7", '{1'b1,1'b1,1'b0,2'd2,2'd1,64'd3,8'hFF,4'd0,8'd3,64'd0,1'b0},
                64'h2000, 4'd2);
        // R9: event on first iteration of many
        run_one("R9", '{1'b1,1'b1,1'b1,2'd3,2'd2,64'd9,8'hFF,4'd1,8'd1,64'd8,1'b1},
                64'h3000, 4'd3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule